// File: doc/BRIEF.md
# DRAM Refresh and Wake-up Sequencer

This block keeps an asynchronous x16 DRAM alive. It runs from one system clock, and every timing value is a parameter given in clock counts. After reset it holds the memory strobes idle for the power-up pause. It then runs a burst of wake-up refresh cycles and only after that reports the memory as ready for ordinary accesses. From then on an interval timer adds one owed refresh per row interval to a backlog, and the block asks the access arbiter for the memory through a request/grant pair.

Each granted refresh runs in one of two modes, chosen by an input that is sampled when the cycle starts. In the CAS-before-RAS form, both byte strobes fall ahead of the row strobe and the device supplies its own row. In the row-strobe-only form, the column strobes stay high and the block presents a row from its own counter, which steps once per such refresh and wraps. Every cycle ends with a precharge gap, and the busy output covers that gap. If the backlog grows past its limit, the refresh period is taken as broken: the ready flag drops and the full wake-up burst runs again.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While reset is held, and for PAUSE_CYC clock edges after it is released, ras_n, casl_n and cash_n are 1 and ref_req, busy and mem_ready are 0. ref_req first reads 1 after edge number PAUSE_CYC counted from release.
- R2: After the pause, exactly WAKE_CNT refresh cycles (ras_n low pulses) take place before mem_ready goes to 1.
- R3: Once ready, one owed refresh is added every INTERVAL_CYC cycles. ref_req is 1 only while refreshes are owed and busy is 0, so it is never 1 during a refresh cycle.
- R4: With mode_ras_only = 0, casl_n and cash_n fall together CSR_CYC cycles before ras_n falls and stay low for CHR_CYC cycles of ras_n low. ras_n is low for RAS_CYC cycles.
- R5: With mode_ras_only = 1, casl_n and cash_n stay 1 for the whole cycle, ras_n is low for RAS_CYC cycles, and row_addr does not change while busy is 1.
- R6: row_addr starts at 0 and steps by one when a row-strobe-only refresh completes. A CAS-before-RAS refresh leaves it unchanged. After 1023 it wraps to 0.
- R7: After ras_n rises, busy stays 1 for RP_CYC cycles of precharge with all strobes high. Only then can another cycle start.
- R8: ref_gnt has no effect while ref_req is 0: no cycle starts and busy stays 0.
- R9: When an interval tick finds BACKLOG_MAX refreshes already owed and no refresh completes in that cycle, mem_ready goes to 0, the backlog is cleared, and WAKE_CNT wake-up cycles run before mem_ready returns to 1.
- R10: When a tick and a refresh completion fall in the same cycle, the owed count is unchanged. This applies even at BACKLOG_MAX, where it does not count as an overflow.
- R11: The mode is captured when the cycle starts. Changing mode_ras_only during a cycle alters neither the strobes nor row_addr for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ras_only | input | 1 | 1 selects row-strobe-only refresh, 0 selects CAS-before-RAS |
| ref_gnt | input | 1 | Arbiter grant; starts a cycle when ref_req is 1 |
| ref_req | output | 1 | Request for the memory to run one refresh |
| busy | output | 1 | A refresh cycle, including its precharge, is in progress |
| mem_ready | output | 1 | Wake-up complete; ordinary accesses allowed |
| ras_n | output | 1 | Row address strobe, active low |
| casl_n | output | 1 | Lower-byte column strobe, active low |
| cash_n | output | 1 | Upper-byte column strobe, active low |
| row_addr | output | ROW_W | Row presented in row-strobe-only refresh |

## Verification
The interval tick and the completion of a refresh can land on the same clock edge, and at a full backlog that edge separates a normal cycle from a forced wake-up. The bench starts the interval timer from a known point by finishing a wake-up burst. It lets the backlog fill to its limit, then issues a grant timed so that the refresh completes on the very edge of the next tick. It judges the result by mem_ready staying high and by exactly BACKLOG_MAX further refreshes being requested before the next tick.

// File: rtl/dref_pkg.sv
// Shared types for the refresh sequencer.
// Assumes: nothing beyond the 2-bit encodings below.
package dref_pkg;

    // phases of one refresh cycle
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_RASLO = 2'd2,
        PH_PRECH = 2'd3
    } dref_phase_e;

    // top-level life cycle
    typedef enum logic [1:0] {
        SQ_PAUSE = 2'd0,
        SQ_WAKE  = 2'd1,
        SQ_RUN   = 2'd2
    } dref_seq_e;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dref_cycle_engine.sv
// Runs one refresh cycle on the strobes: optional CAS setup, RAS low, precharge.
// Assumes: CSR_CYC, RAS_CYC, RP_CYC >= 1 and 1 <= CHR_CYC <= RAS_CYC; start only when idle.
module dref_cycle_engine
    import dref_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int CHR_CYC = 1,
    parameter int RAS_CYC = 5,
    parameter int RP_CYC  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mode_ras_only,
    output logic ras_n,
    output logic cas_n,
    output logic busy,
    output logic done,
    output logic mode_q
);

    localparam int LONGEST = max_of3(CSR_CYC, RAS_CYC + CHR_CYC, RP_CYC);
    localparam int CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] CSR_LAST = CW'(CSR_CYC - 1);
    localparam logic [CW-1:0] RAS_LAST = CW'(RAS_CYC - 1);
    localparam logic [CW-1:0] RP_LAST  = CW'(RP_CYC - 1);
    localparam logic [CW-1:0] CHR_LIM  = CW'(CHR_CYC);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    dref_phase_e   ph;
    logic [CW-1:0] cnt;

    // phase sequencing with a per-phase cycle counter; mode captured at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            mode_q <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        mode_q <= mode_ras_only;
                        cnt    <= '0;
                        ph     <= mode_ras_only ? PH_RASLO : PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt == CSR_LAST) begin
                        cnt <= '0;
                        ph  <= PH_RASLO;
                    end else begin
                        cnt <= cnt + CNT_ONE;
                    end
                end
                PH_RASLO: begin
                    if (cnt == RAS_LAST) begin
                        cnt <= '0;
                        ph  <= PH_PRECH;
                    end else begin
                        cnt <= cnt + CNT_ONE;
                    end
                end
                default: begin
                    if (cnt == RP_LAST) begin
                        cnt <= '0;
                        ph  <= PH_IDLE;
                    end else begin
                        cnt <= cnt + CNT_ONE;
                    end
                end
            endcase
        end
    end

    // strobe and status decode from the phase registers
    always_comb begin
        ras_n = (ph != PH_RASLO);
        cas_n = !((ph == PH_SETUP) || ((ph == PH_RASLO) && !mode_q && (cnt < CHR_LIM)));
        busy  = (ph != PH_IDLE);
        done  = (ph == PH_PRECH) && (cnt == RP_LAST);
    end

    AST_CBR_CAS_LEADS: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ras_n) && !mode_q) |-> (!cas_n && $past(!cas_n))); // R4
    AST_RASONLY_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (busy && mode_q) |-> cas_n); // R5
    AST_PRECH_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n) $rose(ras_n) |-> (busy && cas_n)); // R7
    AST_DONE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n) done |-> (ras_n && cas_n)); // R7

endmodule

// File: rtl/dref_interval_timer.sv
// Free-running row-interval timer; pulses tick once every INTERVAL_CYC enabled cycles.
// Assumes: INTERVAL_CYC >= 2; disabling restarts the interval from zero.
module dref_interval_timer #(
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int TW = $clog2(INTERVAL_CYC + 1);
    localparam logic [TW-1:0] T_LAST = TW'(INTERVAL_CYC - 1);
    localparam logic [TW-1:0] T_ONE  = TW'(1);

    logic [TW-1:0] tcnt;

    // count enabled cycles, wrap at the interval, clear when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            tcnt <= '0;
        end else if (tcnt == T_LAST) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + T_ONE;
        end
    end

    assign tick = en && (tcnt == T_LAST);

    AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R3

endmodule

// File: rtl/dref_backlog.sv
// Counts refreshes owed; flags overflow when a tick arrives at the cap with no completion.
// Assumes: clear has priority; dec only follows a refresh that was owed.
module dref_backlog #(
    parameter int BACKLOG_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    input  logic dec,
    output logic pending,
    output logic overflow
);

    localparam int BW = $clog2(BACKLOG_MAX + 1);
    localparam logic [BW-1:0] CAP    = BW'(BACKLOG_MAX);
    localparam logic [BW-1:0] B_ONE  = BW'(1);

    logic [BW-1:0] owed;

    // up on tick, down on completion, unchanged when both coincide
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            owed <= '0;
        end else if (inc && !dec && (owed != CAP)) begin
            owed <= owed + B_ONE;
        end else if (dec && !inc && (owed != '0)) begin
            owed <= owed - B_ONE;
        end
    end

    assign overflow = inc && !dec && (owed == CAP);
    assign pending  = (owed != '0);

    AST_BACKLOG_CAP: assert property (@(posedge clk) disable iff (!rst_n) owed <= CAP); // R9
    AST_COINCIDE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (inc && dec && !clear) |=> (owed == $past(owed))); // R10

endmodule

// File: rtl/dref_row_counter.sv
// Row counter for row-strobe-only refresh; steps once per completed refresh.
// Assumes: natural binary wrap at 2**ROW_W - 1.
module dref_row_counter #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);

    localparam logic [ROW_W-1:0] R_ONE = ROW_W'(1);

    // advance to the next row after each completed row-strobe-only cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step) begin
            row <= row + R_ONE;
        end
    end

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (step && (row == '1)) |=> (row == '0)); // R6

endmodule

// File: rtl/dram_refresh_sequencer.sv
// Power-up pause, wake-up burst and periodic refresh for an asynchronous x16 DRAM.
// Every refresh cycle goes through the ref_req/ref_gnt handshake; a burst is a run of single grants.
// Assumes: the arbiter issues no accesses while mem_ready is 0 and yields the memory on ref_gnt.
module dram_refresh_sequencer
    import dref_pkg::*;
#(
    parameter int PAUSE_CYC    = 20000,
    parameter int INTERVAL_CYC = 1560,
    parameter int WAKE_CNT     = 8,
    parameter int BACKLOG_MAX  = 8,
    parameter int CSR_CYC      = 1,
    parameter int CHR_CYC      = 1,
    parameter int RAS_CYC      = 5,
    parameter int RP_CYC       = 5,
    parameter int ROW_W        = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ras_only,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             busy,
    output logic             mem_ready,
    output logic             ras_n,
    output logic             casl_n,
    output logic             cash_n,
    output logic [ROW_W-1:0] row_addr
);

    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int WW = $clog2(WAKE_CNT + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
    localparam logic [PW-1:0] P_ONE      = PW'(1);
    localparam logic [WW-1:0] WAKE_INIT  = WW'(WAKE_CNT);
    localparam logic [WW-1:0] W_ONE      = WW'(1);

    dref_seq_e     sq;
    logic [PW-1:0] pcnt;
    logic [WW-1:0] wake_left;

    logic eng_busy, eng_done, eng_mode_q, eng_cas_n, eng_start;
    logic tick, bl_pending, bl_overflow;
    logic need;

    // life-cycle sequencing: pause, wake-up burst, then steady refresh
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq        <= SQ_PAUSE;
            pcnt      <= '0;
            wake_left <= '0;
        end else begin
            case (sq)
                SQ_PAUSE: begin
                    if (pcnt == PAUSE_LAST) begin
                        sq        <= SQ_WAKE;
                        wake_left <= WAKE_INIT;
                    end else begin
                        pcnt <= pcnt + P_ONE;
                    end
                end
                SQ_WAKE: begin
                    if (eng_done) begin
                        if (wake_left == W_ONE) begin
                            sq <= SQ_RUN;
                        end
                        wake_left <= wake_left - W_ONE;
                    end
                end
                SQ_RUN: begin
                    if (bl_overflow) begin
                        sq        <= SQ_WAKE;
                        wake_left <= WAKE_INIT;
                    end
                end
                default: sq <= SQ_PAUSE;
            endcase
        end
    end

    // request whenever a refresh is owed and the strobes are free
    always_comb begin
        need      = (sq == SQ_WAKE) || ((sq == SQ_RUN) && bl_pending);
        ref_req   = need && !eng_busy;
        eng_start = ref_req && ref_gnt;
        mem_ready = (sq == SQ_RUN);
    end

    dref_interval_timer #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (sq == SQ_RUN),
        .tick (tick)
    );

    dref_backlog #(
        .BACKLOG_MAX(BACKLOG_MAX)
    ) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((sq != SQ_RUN) || bl_overflow),
        .inc     (tick),
        .dec     (eng_done && (sq == SQ_RUN)),
        .pending (bl_pending),
        .overflow(bl_overflow)
    );

    dref_cycle_engine #(
        .CSR_CYC(CSR_CYC),
        .CHR_CYC(CHR_CYC),
        .RAS_CYC(RAS_CYC),
        .RP_CYC (RP_CYC)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (eng_start),
        .mode_ras_only(mode_ras_only),
        .ras_n        (ras_n),
        .cas_n        (eng_cas_n),
        .busy         (eng_busy),
        .done         (eng_done),
        .mode_q       (eng_mode_q)
    );

    dref_row_counter #(
        .ROW_W(ROW_W)
    ) u_rows (
        .clk  (clk),
        .rst_n(rst_n),
        .step (eng_done && eng_mode_q),
        .row  (row_addr)
    );

    assign busy   = eng_busy;
    assign casl_n = eng_cas_n;
    assign cash_n = eng_cas_n;

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (sq == SQ_PAUSE) |-> (ras_n && casl_n && cash_n && !ref_req && !busy)); // R1
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_ready) |-> $past(eng_done)); // R2
    AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(ref_req && ref_gnt)); // R8
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n) (eng_done && eng_mode_q) |=> (row_addr == ROW_W'($past(row_addr) + ROW_W'(1)))); // R6
    AST_ROW_CBR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (eng_done && !eng_mode_q) |=> $stable(row_addr)); // R6
    AST_ROW_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(row_addr)); // R5
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(eng_mode_q)); // R11
    AST_OVERFLOW_WAKE: assert property (@(posedge clk) disable iff (!rst_n) bl_overflow |=> !mem_ready); // R9

endmodule

// File: tb/dram_refresh_sequencer_test.sv
module dram_refresh_sequencer_test;

    localparam int PAUSE_CYC    = 20;
    localparam int INTERVAL_CYC = 40;
    localparam int WAKE_CNT     = 8;
    localparam int BACKLOG_MAX  = 3;
    localparam int CSR_CYC      = 2;
    localparam int CHR_CYC      = 3;
    localparam int RAS_CYC      = 5;
    localparam int RP_CYC       = 3;
    localparam int CYC_LEN      = CSR_CYC + RAS_CYC + RP_CYC;

    // fields: mode, flip mode mid-cycle, setup, ras-low, cas-hold, precharge, row step
    localparam int NVEC = 6;
    localparam int VEC [NVEC][7] = '{
        '{0, 0, CSR_CYC, RAS_CYC, CHR_CYC, RP_CYC, 0},
        '{1, 0, 0,       RAS_CYC, 0,       RP_CYC, 1},
        '{0, 1, CSR_CYC, RAS_CYC, CHR_CYC, RP_CYC, 0},
        '{1, 1, 0,       RAS_CYC, 0,       RP_CYC, 1},
        '{1, 0, 0,       RAS_CYC, 0,       RP_CYC, 1},
        '{0, 0, CSR_CYC, RAS_CYC, CHR_CYC, RP_CYC, 0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_ras_only = 1'b0;
    logic       gnt_drv = 1'b0;
    logic       auto_gnt = 1'b0;
    logic       ref_gnt, ref_req, busy, mem_ready, ras_n, casl_n, cash_n;
    logic [9:0] row_addr;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int exp_row = 0;
    bit finished = 1'b0;

    assign ref_gnt = gnt_drv | (auto_gnt & ref_req);

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_sequencer #(
        .PAUSE_CYC(PAUSE_CYC), .INTERVAL_CYC(INTERVAL_CYC), .WAKE_CNT(WAKE_CNT),
        .BACKLOG_MAX(BACKLOG_MAX), .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC),
        .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC), .ROW_W(10)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mode_ras_only(mode_ras_only), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .busy(busy), .mem_ready(mem_ready), .ras_n(ras_n),
        .casl_n(casl_n), .cash_n(cash_n), .row_addr(row_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // grant one cycle when requested, then measure its strobe shape
    task automatic run_cycle(input logic m, input logic flip,
                             output int n_setup, output int n_lo, output int n_hold,
                             output int n_pre, output int row_fall,
                             output int req_bad, output int row_moved);
        int  waited = 0;
        bit  fell = 1'b0;
        n_setup = 0; n_lo = 0; n_hold = 0; n_pre = 0; row_fall = -1; req_bad = 0; row_moved = 0;
        mode_ras_only = m;
        @(negedge clk);
        while (!ref_req && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        gnt_drv = 1'b1;
        @(negedge clk);
        gnt_drv = 1'b0;
        if (flip) mode_ras_only = !m;
        while (busy) begin
            if (ref_req) req_bad++;
            if (!ras_n) begin
                if (!fell) row_fall = int'(row_addr);
                else if (int'(row_addr) != row_fall) row_moved++;
                fell = 1'b1;
                n_lo++;
                if (!casl_n || !cash_n) n_hold++;
            end else if (!fell) begin
                if (!casl_n && !cash_n) n_setup++;
            end else begin
                n_pre++;
            end
            @(negedge clk);
        end
        mode_ras_only = m;
    endtask

    // auto-grant until mem_ready; count ras_n falls and those without CAS low
    task automatic run_burst(output int n_fall, output int n_noncbr, output int ready_cyc);
        bit prev_ras = 1'b1;
        int guard = 0;
        n_fall = 0; n_noncbr = 0;
        auto_gnt = 1'b1;
        while (!mem_ready && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (prev_ras && !ras_n) begin
                n_fall++;
                if (casl_n || cash_n) n_noncbr++;
            end
            prev_ras = ras_n;
        end
        auto_gnt = 1'b0;
        ready_cyc = cyc;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int k, nf, nnc, e1, s, lo, h, p, rf, rb, rm, falls, bad_rows;
        bit prev;
        bit seen_wrap;

        // reset state
        repeat (3) @(negedge clk);
        chk("R1 ras_n in reset", int'(ras_n), 1);
        chk("R1 cas in reset", int'(casl_n & cash_n), 1);
        chk("R1 req/busy/ready in reset", int'({ref_req, busy, mem_ready}), 0);
        rst_n = 1'b1;

        // pause length: edges from release until ref_req
        k = 0;
        nb = 0;
        while (!ref_req && k < 200) begin
            @(negedge clk);
            k++;
            if (!ref_req && (!ras_n || busy || mem_ready || !casl_n)) nb++;
        end
        chk("R1 pause edges before request", k, PAUSE_CYC);
        chk("R1 strobes quiet during pause", nb, 0);

        // wake-up burst
        run_burst(nf, nnc, e1);
        chk("R2 wake-up cycles before ready", nf, WAKE_CNT);
        chk("R2 wake-up cycles are CBR", nnc, 0);

        // table of single refreshes
        for (int v = 0; v < NVEC; v++) begin
            run_cycle(VEC[v][0] != 0, VEC[v][1] != 0, s, lo, h, p, rf, rb, rm);
            chk($sformatf("R4 vec%0d CAS setup", v), s, VEC[v][2]);
            chk($sformatf("R4 vec%0d RAS low", v), lo, VEC[v][3]);
            chk($sformatf("R11 vec%0d CAS hold", v), h, VEC[v][4]);
            chk($sformatf("R7 vec%0d precharge", v), p, VEC[v][5]);
            chk($sformatf("R3 vec%0d no req while busy", v), rb, 0);
            chk($sformatf("R5 vec%0d row at RAS fall", v), rf, exp_row);
            chk($sformatf("R5 vec%0d row steady", v), rm, 0);
            exp_row = (exp_row + VEC[v][6]) % 1024;
            chk($sformatf("R6 vec%0d row after", v), int'(row_addr), exp_row);
        end

        // grant without request is ignored
        for (int i = 0; i < 3; i++) begin
            k = 0;
            while ((ref_req || busy) && k < 5000) begin
                auto_gnt = 1'b1;
                @(negedge clk);
                k++;
            end
            auto_gnt = 1'b0;
            gnt_drv = 1'b1;
            @(negedge clk);
            gnt_drv = 1'b0;
            chk("R8 grant with no request", int'({busy, ~ras_n}), 0);
        end

        // backlog overflow forces a new wake-up burst
        mode_ras_only = 1'b0;
        k = 0;
        while (mem_ready && k < (BACKLOG_MAX + 3) * INTERVAL_CYC) begin
            @(negedge clk);
            k++;
        end
        chk("R9 ready drops on overflow", int'(mem_ready), 0);
        run_burst(nf, nnc, e1);
        chk("R9 repeated wake-up cycles", nf, WAKE_CNT);
        chk("R9 ready restored", int'(mem_ready), 1);

        // tick and completion on the same edge at a full backlog
        while (cyc < e1 + (BACKLOG_MAX + 1) * INTERVAL_CYC - CYC_LEN - 1) @(negedge clk);
        gnt_drv = 1'b1;
        @(negedge clk);
        gnt_drv = 1'b0;
        chk("R10 timed cycle started", int'(busy), 1);
        while (cyc < e1 + (BACKLOG_MAX + 1) * INTERVAL_CYC) @(negedge clk);
        auto_gnt = 1'b1;
        falls = 0;
        nb = 0;
        prev = ras_n;
        while (cyc < e1 + (BACKLOG_MAX + 2) * INTERVAL_CYC - 1) begin
            @(negedge clk);
            if (prev && !ras_n) falls++;
            if (!mem_ready) nb++;
            prev = ras_n;
        end
        auto_gnt = 1'b0;
        chk("R10 no overflow on coincident edge", nb, 0);
        chk("R10 backlog kept at limit", falls, BACKLOG_MAX);

        // row counter wrap with row-strobe-only refresh
        mode_ras_only = 1'b1;
        auto_gnt = 1'b1;
        falls = 0;
        bad_rows = 0;
        seen_wrap = 1'b0;
        k = 1024 - exp_row + 2;
        prev = ras_n;
        while (falls < k && cyc < 180000) begin
            @(negedge clk);
            if (prev && !ras_n) begin
                falls++;
                if (int'(row_addr) != exp_row) bad_rows++;
                if (exp_row == 0 && falls > 1) seen_wrap = 1'b1;
                exp_row = (exp_row + 1) % 1024;
            end
            prev = ras_n;
        end
        auto_gnt = 1'b0;
        chk("R6 rows in sequence", bad_rows, 0);
        chk("R6 wrap 1023 to 0 seen", int'(seen_wrap), 1);
        chk("R3 ready during steady refresh", int'(mem_ready), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    int nb;

endmodule